// File: doc/BRIEF.md
# Serial Management Port Slave

This block is the device-side end of a two-wire serial management link. It runs on the management clock and samples the data line on each rising edge. It looks for a long run of ones followed by a start marker, and then decodes an operation code, a device address and a register address. When the frame is addressed to this device, the block either hands a 16-bit value to a register bank or fetches one from it and sends it back over the shared line.

The shared line is bidirectional. The block offers a data output together with an output enable, so that a pad outside the block can form the tri-state driver. The line is treated as pulled high whenever nobody drives it. A single strap input selects which of two device addresses the block answers to. The register bank is outside the block. It sees a one-cycle read request and a one-cycle write strobe, and it returns read data one clock after a request.

Top module: `mgmt_serial_slave`

## Requirements
- R1: While reset is held and on the first cycle after it, mdio_oe, reg_rd and reg_wr are all 0.
- R2: A frame is decoded only if at least 32 consecutive ones are sampled, then a 0, then a 1. A run of only 31 ones is followed by no strobe and no drive. A run of more than 32 ones is accepted.
- R3: The operation field is two bits, sent first-bit-first. 10 selects a read and 01 selects a write. 00 and 11 cause no strobe and no drive.
- R4: The five device address bits must equal 00000 when strap_sel is 0, and 00011 when strap_sel is 1. Any other value causes no strobe and no drive.
- R5: In a read, reg_rd is high for exactly one cycle, starting one clock after the last register-address bit is sampled. During that cycle reg_addr holds the 5-bit register field, sent most significant bit first. reg_rdata is captured two clocks after the last register-address bit.
- R6: In a read, mdio_oe stays low during the first turnaround slot. The block then drives 0 for the second slot, followed by the 16 data bits, most significant first, one per clock. After that it releases the line, so mdio_oe is high for exactly 17 clocks.
- R7: In a write, the two turnaround bits are not checked. reg_wr is high for exactly one cycle, starting one clock after the 16th data bit is sampled. During that cycle reg_addr and reg_wdata carry the register field and the data, both most significant bit first. mdio_oe stays low throughout.
- R8: After any frame, whether completed or rejected, a new run of 32 ones is needed before another frame is decoded. A start marker that follows directly is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strap_sel | input | 1 | Address strap: 0 answers device 0, 1 answers device 3 |
| mdio_in | input | 1 | Sampled value of the shared data line |
| mdio_out | output | 1 | Value driven onto the line while mdio_oe is high |
| mdio_oe | output | 1 | Output enable for the line driver |
| reg_addr | output | 5 | Register index for read request and write strobe |
| reg_rd | output | 1 | One-cycle read request to the register bank |
| reg_rdata | input | 16 | Read data from the bank, valid one clock after reg_rd |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Write data accompanying reg_wr |

## Verification
The bench sweeps all 32 device address values under both strap settings. A decoder that ignored the upper three address bits, or that compared against the wrong strap pattern, would answer foreign frames and produce strobes or drive where none are allowed. Preamble runs of 31, 32 and 40 ones, invalid operation codes and a broken start marker are all sent, which exposes an off-by-one preamble counter or a lax opcode check. Read data is collected bit by bit from the line across all 32 registers, each holding a distinct computed pattern. A one-slot shift in the turnaround, a reversed bit order or a drive window that is one clock too long therefore shows up as wrong data or a wrong drive count. Frames sent with no fresh preamble catch a design that re-arms without counting the ones again.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [2:0] {
    S_HUNT, S_ST1, S_OP, S_DEV, S_REG, S_TA, S_RDAT, S_WDAT
  } mss_state_t;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mss_preamble.sv
// Counts consecutive ones while the controller is hunting; saturates at PRE_LEN.
module mss_preamble #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_in,
  output logic full
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(PRE_LEN);

  logic [CW-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst || !en || !bit_in) ones <= '0;
    else if (ones != LIM)      ones <= ones + 1'b1;
  end

  assign full = (ones == LIM);
endmodule

// File: rtl/mss_frame_ctl.sv
// Field sequencer: start marker, opcode, device and register address, turnaround, data.
module mss_frame_ctl
  import mss_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 5,
  parameter int DEV_AW = 5,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_in,
  input  logic              strap,
  input  logic              pre_full,
  output logic              hunting,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              tx_zero,
  output logic              tx_load,
  output logic              tx_shift,
  output logic              tx_release
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] L_TWO = CW'(1);
  localparam logic [CW-1:0] L_DEV = CW'(DEV_AW - 1);
  localparam logic [CW-1:0] L_REG = CW'(REG_AW - 1);
  localparam logic [CW-1:0] L_DAT = CW'(DATA_W - 1);
  localparam int HI_W = DEV_AW - SEL_W;

  mss_state_t        state;
  logic [CW-1:0]     cnt;
  logic              is_rd;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_next;
  logic [DEV_AW-1:0] own_dev;

  assign sh_next = {sh[DATA_W-2:0], mdio_in};
  assign own_dev = {{HI_W{1'b0}}, {SEL_W{strap}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_HUNT;
      cnt       <= '0;
      is_rd     <= 1'b0;
      sh        <= '0;
      reg_addr  <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      sh     <= sh_next;
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      case (state)
        S_HUNT: if (!mdio_in && pre_full) state <= S_ST1;
        S_ST1: begin
          cnt   <= '0;
          state <= mdio_in ? S_OP : S_HUNT;
        end
        S_OP: begin
          if (cnt == L_TWO) begin
            cnt <= '0;
            if (sh_next[1:0] == OP_RD) begin
              is_rd <= 1'b1;
              state <= S_DEV;
            end else if (sh_next[1:0] == OP_WR) begin
              is_rd <= 1'b0;
              state <= S_DEV;
            end else begin
              state <= S_HUNT;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DEV: begin
          if (cnt == L_DEV) begin
            cnt   <= '0;
            state <= (sh_next[DEV_AW-1:0] == own_dev) ? S_REG : S_HUNT;
          end else cnt <= cnt + 1'b1;
        end
        S_REG: begin
          if (cnt == L_REG) begin
            cnt      <= '0;
            reg_addr <= sh_next[REG_AW-1:0];
            reg_rd   <= is_rd;
            state    <= S_TA;
          end else cnt <= cnt + 1'b1;
        end
        S_TA: begin
          if (cnt == L_TWO) begin
            cnt   <= '0;
            state <= is_rd ? S_RDAT : S_WDAT;
          end else cnt <= cnt + 1'b1;
        end
        S_RDAT: begin
          if (cnt == L_DAT) begin
            cnt   <= '0;
            state <= S_HUNT;
          end else cnt <= cnt + 1'b1;
        end
        S_WDAT: begin
          if (cnt == L_DAT) begin
            cnt       <= '0;
            reg_wdata <= sh_next;
            reg_wr    <= 1'b1;
            state     <= S_HUNT;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_HUNT;
      endcase
    end
  end

  always_comb begin
    hunting    = (state == S_HUNT);
    tx_zero    = (state == S_TA) && (cnt == '0) && is_rd;
    tx_load    = (state == S_TA) && (cnt == L_TWO) && is_rd;
    tx_shift   = (state == S_RDAT) && (cnt != L_DAT);
    tx_release = (state == S_RDAT) && (cnt == L_DAT);
  end
endmodule

// File: rtl/mss_tx_drive.sv
// Registered line driver: turnaround zero, then read data MSB first.
module mss_tx_drive #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero,
  input  logic              load,
  input  logic              shift,
  input  logic              release_line,
  input  logic [DATA_W-1:0] rdata,
  output logic              mdio_out,
  output logic              mdio_oe
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (zero) begin
      mdio_oe  <= 1'b1;
      mdio_out <= 1'b0;
    end else if (load) begin
      sh       <= rdata;
      mdio_out <= rdata[DATA_W-1];
    end else if (shift) begin
      sh       <= {sh[DATA_W-2:0], 1'b0};
      mdio_out <= sh[DATA_W-2];
    end else if (release_line) begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end
  end
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int REG_AW  = 5,
  parameter int DEV_AW  = 5,
  parameter int SEL_W   = 2
) (
  input  logic              mdc,
  input  logic              rst,
  input  logic              strap_sel,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata
);
  logic hunting, pre_full;
  logic tx_zero, tx_load, tx_shift, tx_release;

  mss_preamble #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk(mdc), .rst(rst), .en(hunting), .bit_in(mdio_in), .full(pre_full)
  );

  mss_frame_ctl #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .DEV_AW(DEV_AW), .SEL_W(SEL_W)
  ) u_ctl (
    .clk(mdc), .rst(rst), .mdio_in(mdio_in), .strap(strap_sel),
    .pre_full(pre_full), .hunting(hunting),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .tx_zero(tx_zero), .tx_load(tx_load), .tx_shift(tx_shift), .tx_release(tx_release)
  );

  mss_tx_drive #(.DATA_W(DATA_W)) u_tx (
    .clk(mdc), .rst(rst), .zero(tx_zero), .load(tx_load), .shift(tx_shift),
    .release_line(tx_release), .rdata(reg_rdata),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 5
) (
  input logic              mdc,
  input logic              rst,
  input logic              mdio_out,
  input logic              mdio_oe,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr
);
  localparam int RW = $clog2(DATA_W + 4);
  localparam logic [RW-1:0] OE_LEN = RW'(DATA_W + 1);

  logic [RW-1:0] oe_run;
  always_ff @(posedge mdc) begin
    if (rst || !mdio_oe) oe_run <= '0;
    else if (oe_run != '1) oe_run <= oe_run + 1'b1;
  end

  // R1: quiet outputs right after reset
  a_r1_reset_quiet: assert property (@(posedge mdc)
    $past(rst) |-> (!mdio_oe && !reg_rd && !reg_wr));
  a_r5_rd_single: assert property (@(posedge mdc) disable iff (rst)
    reg_rd |=> !reg_rd);
  a_r5_no_drive_at_req: assert property (@(posedge mdc) disable iff (rst)
    reg_rd |-> !mdio_oe);
  a_r6_drive_after_req: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> $past(reg_rd));
  a_r6_ta_zero: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_out);
  a_r6_drive_len: assert property (@(posedge mdc) disable iff (rst)
    $fell(mdio_oe) |-> (oe_run == OE_LEN));
  a_r7_wr_single: assert property (@(posedge mdc) disable iff (rst)
    reg_wr |=> !reg_wr);
  a_r7_no_drive_on_wr: assert property (@(posedge mdc) disable iff (rst)
    reg_wr |-> !mdio_oe);
  a_r7_addr_held: assert property (@(posedge mdc) disable iff (rst)
    reg_wr |-> $stable(reg_addr));
endmodule

bind mgmt_serial_slave mss_checker #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .mdc(mdc), .rst(rst), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
  .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/tb_mgmt_serial_slave.sv
module tb_mgmt_serial_slave;
  logic        mdc = 1'b0;
  logic        rst = 1'b1;
  logic        strap_sel = 1'b0;
  logic        mdio_in = 1'b1;
  logic        mdio_out, mdio_oe, reg_rd, reg_wr;
  logic [4:0]  reg_addr;
  logic [15:0] reg_rdata = '0;
  logic [15:0] reg_wdata;

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, n_oe = 0;
  bit done = 0;

  always #2 mdc = ~mdc;

  mgmt_serial_slave dut (
    .mdc(mdc), .rst(rst), .strap_sel(strap_sel), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

  // Stand-in register bank: synchronous write, one-clock read.
  logic [15:0] bank [32];
  always @(posedge mdc) begin
    if (reg_wr) bank[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= bank[reg_addr];
  end

  always @(negedge mdc) if (!rst) begin
    if (reg_rd)  n_rd++;
    if (reg_wr)  n_wr++;
    if (mdio_oe) n_oe++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge mdc);
    mdio_in = b;
  endtask

  function automatic logic [15:0] pat(input int ra);
    return 16'(16'h5A3C ^ (ra * 16'h0841));
  endfunction

  task automatic head(input int pre, input logic [1:0] st, input logic [1:0] op,
                      input logic [4:0] dev, input logic [4:0] ra);
    slot(1'b0);
    repeat (pre) slot(1'b1);
    slot(st[1]); slot(st[0]);
    slot(op[1]); slot(op[0]);
    for (int i = 4; i >= 0; i--) slot(dev[i]);
    for (int i = 4; i >= 0; i--) slot(ra[i]);
  endtask

  task automatic do_write(input string req, input int pre, input logic [4:0] dev,
                          input logic [4:0] ra, input logic [15:0] data, input bit ok);
    int w0 = n_wr, o0 = n_oe;
    head(pre, 2'b01, 2'b01, dev, ra);
    slot(1'b1); slot(1'b0);
    for (int i = 15; i >= 0; i--) slot(data[i]);
    slot(1'b1);
    if (ok) begin
      chk({req, " wr strobe"}, reg_wr, 1);
      chk({req, " wr addr"}, reg_addr, ra);
      chk({req, " wr data"}, reg_wdata, data);
    end
    slot(1'b1);
    chk({req, " wr count"}, n_wr - w0, ok ? 1 : 0);
    chk({req, " no drive on write"}, n_oe - o0, 0);
  endtask

  task automatic do_read(input string req, input int pre, input logic [1:0] st,
                         input logic [1:0] op, input logic [4:0] dev, input logic [4:0] ra,
                         input bit ok, input logic [15:0] exp);
    int r0 = n_rd, w0 = n_wr, o0 = n_oe;
    logic [15:0] got;
    head(pre, st, op, dev, ra);
    slot(1'b1);
    if (ok) chk({req, " ta1 req/addr/oe"}, {reg_rd, reg_addr, mdio_oe}, {1'b1, ra, 1'b0});
    slot(1'b1);
    if (ok) chk({req, " ta2 drives 0"}, {mdio_oe, mdio_out}, 2'b10);
    for (int i = 15; i >= 0; i--) begin
      slot(1'b1);
      got[i] = mdio_oe ? mdio_out : 1'b1;
    end
    slot(1'b1);
    chk({req, " released"}, mdio_oe, 0);
    if (ok) chk({req, " read data"}, got, exp);
    chk({req, " drive cycles"}, n_oe - o0, ok ? 17 : 0);
    chk({req, " rd count"}, n_rd - r0, ok ? 1 : 0);
    chk({req, " no write"}, n_wr - w0, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge mdc);
    chk("R1 in reset", {mdio_oe, reg_rd, reg_wr}, 3'b000);
    rst = 1'b0;
    @(negedge mdc);
    chk("R1 after reset", {mdio_oe, reg_rd, reg_wr}, 3'b000);

    // R7 then R5/R6: fill every register, read every one back (strap 0, device 0)
    for (int ra = 0; ra < 32; ra++) do_write("R7 fill", 32, 5'd0, 5'(ra), pat(ra), 1);
    for (int ra = 0; ra < 32; ra++)
      do_read("R5 R6 readback", 32, 2'b01, 2'b10, 5'd0, 5'(ra), 1, pat(ra));

    // R4: device address sweep under both strap values
    for (int s = 0; s < 2; s++) begin
      strap_sel = 1'(s);
      for (int d = 0; d < 32; d++)
        do_write("R4 dev sweep", 32, 5'(d), 5'd7, 16'(16'hC000 | (s << 8) | d),
                 d == (s != 0 ? 3 : 0));
    end
    for (int d = 0; d < 32; d++)
      do_read("R4 dev sweep rd", 32, 2'b01, 2'b10, 5'(d), 5'd7, d == 3, 16'hC103);

    // R3: invalid opcodes
    do_read("R3 op 00", 32, 2'b01, 2'b00, 5'd3, 5'd7, 0, 16'h0);
    do_read("R3 op 11", 32, 2'b01, 2'b11, 5'd3, 5'd7, 0, 16'h0);
    do_read("R3 reg untouched", 32, 2'b01, 2'b10, 5'd3, 5'd7, 1, 16'hC103);

    // R2: preamble length and start marker
    do_write("R2 short preamble", 31, 5'd3, 5'd9, 16'h1234, 0);
    do_read("R2 short kept", 32, 2'b01, 2'b10, 5'd3, 5'd9, 1, pat(9));
    do_write("R2 long preamble", 40, 5'd3, 5'd9, 16'hBEEF, 1);
    do_read("R2 long readback", 40, 2'b01, 2'b10, 5'd3, 5'd9, 1, 16'hBEEF);
    do_read("R2 bad start", 32, 2'b00, 2'b10, 5'd3, 5'd9, 0, 16'h0);

    // R8: no fresh preamble after completed or rejected frames
    do_write("R8 setup", 32, 5'd3, 5'd4, 16'h0F0F, 1);
    do_write("R8 no preamble after write", 0, 5'd3, 5'd4, 16'hFFFF, 0);
    do_read("R8 no preamble after reject", 0, 2'b01, 2'b10, 5'd3, 5'd4, 0, 16'h0);
    do_read("R8 readback", 32, 2'b01, 2'b10, 5'd3, 5'd4, 1, 16'h0F0F);
    do_read("R8 no preamble after read", 0, 2'b01, 2'b10, 5'd3, 5'd4, 0, 16'h0);

    repeat (4) slot(1'b1);
    done = 1;
    summary();
    $finish;
  end
endmodule